// File: doc/BRIEF.md
# JTAG Debug Register Access Port

This block is a JTAG test access port through which a host reaches a bank of 32-bit debug registers and two 8-bit power registers. It runs the sixteen-state TAP controller on TCK, holds a 5-bit instruction register, and selects one of several data registers: the identification code, the one-bit bypass, the power control byte, the power status byte and the debug register access path.

The debug registers are reached in two data scans under one instruction. The first is an 8-bit address scan. It holds the register number in bits 7:1 and the direction in bit 0. The second is a 32-bit data scan. On a write, that scan carries the value. The block then pulses a write strobe on a simple register-side bus. On a read, the block pulses a read strobe right after the address scan. The returned word is captured at the start of the data scan and shifted out to the host.

The register-side bus runs in the TCK domain. The debug registers themselves lie outside the block.

Top module: `dbg_tap`

## Requirements
- R1: The TAP controller follows the sixteen-state JTAG graph. It reaches Test-Logic-Reset after five rising TCK edges with TMS high, from any state, and at once when `trst_n` is low. In that state the instruction is IDCODE and the access sequence is back at the address scan.
- R2: The instruction register is 5 bits and captures 5'b00001 in Capture-IR. The codes are 0x08 for power control, 0x09 for power status, 0x1C for register access, 0x1E for IDCODE and 0x1F for BYPASS. Any other code acts as BYPASS.
- R3: Under IDCODE, a 32-bit scan returns the `IDCODE_VAL` parameter. All scans shift least significant bit first: TDI enters at the top of the selected register and TDO is its bit 0.
- R4: The BYPASS register is 1 bit and captures 0. A scan through it returns the input delayed by one bit.
- R5: Under 0x08, an 8-bit scan captures the current power control byte. On Update-DR the byte shifted in is stored and driven on `pwr_ctrl`. `pwr_ctrl` is 0 after `trst_n`.
- R6: Under 0x09, an 8-bit scan captures the power status byte. On Update-DR, each bit that is 1 in the shifted-in byte clears the matching status bit. A high bit of `pwr_evt` sets its status bit on every TCK edge, and a set wins over a clear in the same edge.
- R7: Under 0x1C, scans alternate between an 8-bit address scan and a 32-bit data scan. In the address scan, bits 7:1 are the register number and bit 0 is 1 for write and 0 for read.
- R8: After the data scan of a write, `reg_wr` is high for exactly one TCK cycle, the one following Update-DR. During that cycle `reg_addr` holds the register number and `reg_wdata` holds the 32 bits shifted in.
- R9: After the address scan of a read, `reg_rd` is high for exactly one TCK cycle, the one following Update-DR, with `reg_addr` valid. The following data scan captures `reg_rdata` and shifts it out least significant bit first.
- R10: A register number above `MAX_REG` produces neither `reg_wr` nor `reg_rd`. Its data scan returns zero.
- R11: Any Update-IR returns the access sequence to the address scan, even when only an address scan was done.
- R12: TDO changes on the falling edge of TCK. It is 0 outside Shift-IR and Shift-DR.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | JTAG test clock |
| trst_n | input | 1 | Asynchronous TAP reset, active low |
| tms | input | 1 | Test mode select |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out, updated on falling TCK |
| pwr_evt | input | 8 | Power status set events, TCK domain |
| pwr_ctrl | output | 8 | Power control byte |
| reg_addr | output | 7 | Debug register number |
| reg_wdata | output | 32 | Debug register write data |
| reg_wr | output | 1 | Write strobe, one TCK cycle |
| reg_rdata | input | 32 | Debug register read data |
| reg_rd | output | 1 | Read strobe, one TCK cycle |

## Verification
Every implemented register number is written with an arithmetic pattern and then read back. This separates address decoding and bit ordering from strobe timing. Every register number above the limit is then tried for both write and read, which tells a range check that is off by one from a correct one.

The power control byte is swept through a series of values, each captured back on the next scan. The power status byte is cleared with overlapping masks, and one case holds an event high during its own clear. An instruction is reloaded between an address scan and its data scan to expose a sequencer that fails to go back to the address scan. Resets by TMS and by TRST are both applied in the middle of scans.

// File: rtl/dbg_tap.sv
module dbg_tap #(
  parameter logic [31:0] IDCODE_VAL = 32'h2C0F_E0A5,
  parameter int          MAX_REG    = 95
) (
  input  logic        tck,
  input  logic        trst_n,
  input  logic        tms,
  input  logic        tdi,
  output logic        tdo,
  input  logic [7:0]  pwr_evt,
  output logic [7:0]  pwr_ctrl,
  output logic [6:0]  reg_addr,
  output logic [31:0] reg_wdata,
  output logic        reg_wr,
  input  logic [31:0] reg_rdata,
  output logic        reg_rd
);

  localparam logic [4:0] OP_PWRCTL  = 5'h08;
  localparam logic [4:0] OP_PWRSTAT = 5'h09;
  localparam logic [4:0] OP_ACCESS  = 5'h1C;
  localparam logic [4:0] OP_IDCODE  = 5'h1E;
  localparam logic [6:0] TOP_REG    = 7'(MAX_REG);

  typedef enum logic [3:0] {
    S_TLR = 4'hF, S_RTI = 4'hC,
    S_SELDR = 4'h7, S_CAPDR = 4'h6, S_SHDR = 4'h2, S_EX1DR = 4'h1,
    S_PAUDR = 4'h3, S_EX2DR = 4'h0, S_UPDDR = 4'h5,
    S_SELIR = 4'h4, S_CAPIR = 4'hE, S_SHIR = 4'hA, S_EX1IR = 4'h9,
    S_PAUIR = 4'hB, S_EX2IR = 4'h8, S_UPDIR = 4'hD
  } tap_state_e;

  tap_state_e  state, nxt;
  logic [4:0]  ir, ir_sh;
  logic [31:0] dr_sh, cap_val;
  logic [7:0]  pwr_stat;
  logic        data_ph, wr_flag;

  always_comb begin
    case (state)
      S_TLR:   nxt = tms ? S_TLR   : S_RTI;
      S_RTI:   nxt = tms ? S_SELDR : S_RTI;
      S_SELDR: nxt = tms ? S_SELIR : S_CAPDR;
      S_CAPDR: nxt = tms ? S_EX1DR : S_SHDR;
      S_SHDR:  nxt = tms ? S_EX1DR : S_SHDR;
      S_EX1DR: nxt = tms ? S_UPDDR : S_PAUDR;
      S_PAUDR: nxt = tms ? S_EX2DR : S_PAUDR;
      S_EX2DR: nxt = tms ? S_UPDDR : S_SHDR;
      S_UPDDR: nxt = tms ? S_SELDR : S_RTI;
      S_SELIR: nxt = tms ? S_TLR   : S_CAPIR;
      S_CAPIR: nxt = tms ? S_EX1IR : S_SHIR;
      S_SHIR:  nxt = tms ? S_EX1IR : S_SHIR;
      S_EX1IR: nxt = tms ? S_UPDIR : S_PAUIR;
      S_PAUIR: nxt = tms ? S_EX2IR : S_PAUIR;
      S_EX2IR: nxt = tms ? S_UPDIR : S_SHIR;
      S_UPDIR: nxt = tms ? S_SELDR : S_RTI;
      default: nxt = S_TLR;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n) state <= S_TLR;
    else         state <= nxt;

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      ir    <= OP_IDCODE;
      ir_sh <= '0;
    end else begin
      case (state)
        S_TLR:   ir    <= OP_IDCODE;
        S_CAPIR: ir_sh <= 5'b00001;
        S_SHIR:  ir_sh <= {tdi, ir_sh[4:1]};
        S_UPDIR: ir    <= ir_sh;
        default: ;
      endcase
    end
  end

  wire op_access = (ir == OP_ACCESS);
  wire addr_ok   = (reg_addr <= TOP_REG);
  wire new_ok    = (dr_sh[7:1] <= TOP_REG);

  always_comb begin
    case (ir)
      OP_IDCODE:  cap_val = IDCODE_VAL;
      OP_PWRCTL:  cap_val = {24'b0, pwr_ctrl};
      OP_PWRSTAT: cap_val = {24'b0, pwr_stat};
      OP_ACCESS:  cap_val = (data_ph && !wr_flag && addr_ok) ? reg_rdata : 32'b0;
      default:    cap_val = 32'b0;
    endcase
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n)
      dr_sh <= '0;
    else if (state == S_CAPDR)
      dr_sh <= cap_val;
    else if (state == S_SHDR) begin
      case (ir)
        OP_IDCODE:             dr_sh <= {tdi, dr_sh[31:1]};
        OP_PWRCTL, OP_PWRSTAT: dr_sh <= {24'b0, tdi, dr_sh[7:1]};
        OP_ACCESS:             dr_sh <= data_ph ? {tdi, dr_sh[31:1]}
                                                : {24'b0, tdi, dr_sh[7:1]};
        default:               dr_sh <= {31'b0, tdi};
      endcase
    end
  end

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      data_ph   <= 1'b0;
      wr_flag   <= 1'b0;
      reg_addr  <= '0;
      reg_wdata <= '0;
      reg_wr    <= 1'b0;
      reg_rd    <= 1'b0;
    end else begin
      reg_wr <= 1'b0;
      reg_rd <= 1'b0;
      if (state == S_TLR || state == S_UPDIR)
        data_ph <= 1'b0;
      else if (state == S_UPDDR && op_access) begin
        data_ph <= !data_ph;
        if (!data_ph) begin
          reg_addr <= dr_sh[7:1];
          wr_flag  <= dr_sh[0];
          reg_rd   <= !dr_sh[0] && new_ok;
        end else if (wr_flag && addr_ok) begin
          reg_wdata <= dr_sh;
          reg_wr    <= 1'b1;
        end
      end
    end
  end

  wire upd_ctl  = (state == S_UPDDR) && (ir == OP_PWRCTL);
  wire upd_stat = (state == S_UPDDR) && (ir == OP_PWRSTAT);

  always_ff @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      pwr_ctrl <= '0;
      pwr_stat <= '0;
    end else begin
      if (upd_ctl) pwr_ctrl <= dr_sh[7:0];
      pwr_stat <= (upd_stat ? (pwr_stat & ~dr_sh[7:0]) : pwr_stat) | pwr_evt;
    end
  end

  always_ff @(negedge tck or negedge trst_n)
    if (!trst_n)              tdo <= 1'b0;
    else if (state == S_SHIR) tdo <= ir_sh[0];
    else if (state == S_SHDR) tdo <= dr_sh[0];
    else                      tdo <= 1'b0;

endmodule

module dbg_tap_chk #(
  parameter int MAX_REG = 95
) (
  input logic       tck,
  input logic       trst_n,
  input logic       tms,
  input logic       tdo,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [6:0] reg_addr,
  input logic [3:0] state
);
  localparam logic [3:0] C_TLR  = 4'hF;
  localparam logic [3:0] C_SHDR = 4'h2;
  localparam logic [3:0] C_SHIR = 4'hA;

  logic [2:0] hi_cnt;
  always_ff @(posedge tck or negedge trst_n)
    if (!trst_n)     hi_cnt <= '0;
    else if (!tms)   hi_cnt <= '0;
    else if (hi_cnt != 3'd5) hi_cnt <= hi_cnt + 3'd1;

  assert_tms_reset_R1: assert property (@(posedge tck) disable iff (!trst_n)
    (hi_cnt == 3'd5) |-> (state == C_TLR));

  assert_one_strobe_R8: assert property (@(posedge tck) disable iff (!trst_n)
    !(reg_wr && reg_rd));

  assert_wr_pulse_R8: assert property (@(posedge tck) disable iff (!trst_n)
    reg_wr |=> !reg_wr);

  assert_rd_pulse_R9: assert property (@(posedge tck) disable iff (!trst_n)
    reg_rd |=> !reg_rd);

  assert_addr_range_R10: assert property (@(posedge tck) disable iff (!trst_n)
    (reg_wr || reg_rd) |-> (int'(reg_addr) <= MAX_REG));

  assert_tdo_idle_R12: assert property (@(posedge tck) disable iff (!trst_n)
    (state != C_SHDR && state != C_SHIR) |-> (tdo == 1'b0));
endmodule

bind dbg_tap dbg_tap_chk #(.MAX_REG(MAX_REG)) u_chk (
  .tck(tck), .trst_n(trst_n), .tms(tms), .tdo(tdo),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr), .state(state)
);

// File: tb/sim_dbg_tap.sv
module sim_dbg_tap;
  localparam int          PER  = 10;
  localparam logic [31:0] IDV  = 32'h4B71_90D3;
  localparam int          MAXR = 95;

  logic        tck = 1'b0, trst_n = 1'b0, tms = 1'b1, tdi = 1'b0;
  logic        tdo, reg_wr, reg_rd;
  logic [7:0]  pwr_evt = 8'h00, pwr_ctrl;
  logic [6:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata, rd_hold = 32'h0;
  logic [31:0] mem [128];
  int          wr_cnt = 0, rd_cnt = 0, nchk = 0, nfail = 0;
  bit          done = 1'b0;

  always #(PER/2) tck = ~tck;

  dbg_tap #(.IDCODE_VAL(IDV), .MAX_REG(MAXR)) u0 (
    .tck(tck), .trst_n(trst_n), .tms(tms), .tdi(tdi), .tdo(tdo),
    .pwr_evt(pwr_evt), .pwr_ctrl(pwr_ctrl), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_wr(reg_wr), .reg_rdata(reg_rdata), .reg_rd(reg_rd)
  );

  assign reg_rdata = rd_hold;

  always @(posedge tck) begin
    if (reg_wr) begin mem[reg_addr] <= reg_wdata; wr_cnt <= wr_cnt + 1; end
    if (reg_rd) begin rd_hold <= mem[reg_addr]; rd_cnt <= rd_cnt + 1; end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic m, input logic d, output logic o);
    @(negedge tck);
    #1;
    o = tdo; tms = m; tdi = d;
  endtask

  task automatic idle(input int n);
    logic o;
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, o);
  endtask

  task automatic ir_scan(input logic [4:0] v, output logic [4:0] cap);
    logic o;
    step(1'b1, 1'b0, o); step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    for (int i = 0; i < 5; i++) begin
      step(i == 4, v[i], o);
      cap[i] = o;
    end
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
    idle(2);
  endtask

  task automatic dr_scan(input int n, input logic [31:0] v, output logic [31:0] cap);
    logic o;
    cap = '0;
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    for (int i = 0; i < n; i++) begin
      step(i == n - 1, v[i], o);
      cap[i] = o;
    end
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o);
    idle(2);
  endtask

  function automatic logic [31:0] pat(input int a);
    return (32'(a) * 32'h0100_0193) ^ 32'hC3A5_0F1E;
  endfunction

  initial begin
    #(PER * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [4:0]  ic;
    logic [31:0] c;
    logic [7:0]  prev, st;
    int          w0, r0;
    logic [7:0]  masks [5];
    logic        o;
    masks = '{8'h0F, 8'h30, 8'h00, 8'hC1, 8'hFF};

    #(PER * 3);
    #1 chk("R12 tdo in reset", 32'(tdo), 0);
    chk("R5 pwr_ctrl after reset", 32'(pwr_ctrl), 0);
    @(negedge tck); #1 trst_n = 1'b1;
    idle(1);
    dr_scan(32, 32'h0, c);
    chk("R3 idcode after reset", c, IDV);

    ir_scan(5'h1F, ic);
    chk("R2 ir capture", 32'(ic), 32'h1);
    for (int k = 0; k < 4; k++) begin
      logic [31:0] v = 32'(9'h1B5 ^ (k * 73)) & 32'h1FF;
      dr_scan(9, v, c);
      chk("R4 bypass delay", c, (v << 1) & 32'h1FF);
    end
    ir_scan(5'h03, ic);
    dr_scan(9, 32'h0FF, c);
    chk("R2 unknown code acts as bypass", c, 32'h1FE);
    ir_scan(5'h1E, ic);
    dr_scan(32, 32'hFFFF_FFFF, c);
    chk("R3 idcode reloaded", c, IDV);

    ir_scan(5'h08, ic);
    prev = 8'h00;
    for (int k = 0; k < 9; k++) begin
      logic [7:0] v = (k == 8) ? 8'hFF : 8'(k * 29 + 3);
      dr_scan(8, 32'(v), c);
      chk("R5 pwr_ctrl capture", c, 32'(prev));
      chk("R5 pwr_ctrl output", 32'(pwr_ctrl), 32'(v));
      prev = v;
    end

    ir_scan(5'h09, ic);
    pwr_evt = 8'hFF; idle(1); pwr_evt = 8'h00;
    st = 8'hFF;
    for (int k = 0; k < 5; k++) begin
      dr_scan(8, 32'(masks[k]), c);
      chk("R6 status capture", c, 32'(st));
      st = st & ~masks[k];
    end
    dr_scan(8, 32'h0, c);
    chk("R6 status fully cleared", c, 32'(st));
    pwr_evt = 8'h01;
    dr_scan(8, 32'hFF, c);
    pwr_evt = 8'h00;
    dr_scan(8, 32'h0, c);
    chk("R6 set wins over clear", c, 32'h01);

    ir_scan(5'h1C, ic);
    for (int a = 0; a <= MAXR; a++) begin
      w0 = wr_cnt; r0 = rd_cnt;
      dr_scan(8, {24'b0, 7'(a), 1'b1}, c);
      dr_scan(32, pat(a), c);
      chk("R8 one write strobe", 32'(wr_cnt - w0), 1);
      chk("R7 write has no read", 32'(rd_cnt - r0), 0);
      chk("R8 write data at address", mem[a], pat(a));
    end
    for (int a = 0; a <= MAXR; a++) begin
      w0 = wr_cnt; r0 = rd_cnt;
      dr_scan(8, {24'b0, 7'(a), 1'b0}, c);
      chk("R9 read strobe after address scan", 32'(rd_cnt - r0), 1);
      dr_scan(32, 32'h0, c);
      chk("R9 read data", c, pat(a));
      chk("R7 read has no write", 32'(wr_cnt - w0), 0);
    end
    for (int a = MAXR + 1; a < 128; a++) begin
      w0 = wr_cnt; r0 = rd_cnt;
      dr_scan(8, {24'b0, 7'(a), 1'b1}, c);
      dr_scan(32, 32'hDEAD_BEEF, c);
      chk("R10 no write above limit", 32'(wr_cnt - w0), 0);
      dr_scan(8, {24'b0, 7'(a), 1'b0}, c);
      dr_scan(32, 32'h0, c);
      chk("R10 no read above limit", 32'(rd_cnt - r0), 0);
      chk("R10 zero data above limit", c, 0);
    end

    dr_scan(8, {24'b0, 7'd5, 1'b1}, c);
    ir_scan(5'h1C, ic);
    w0 = wr_cnt;
    dr_scan(8, {24'b0, 7'd6, 1'b0}, c);
    dr_scan(32, 32'h0, c);
    chk("R11 address phase after new instruction", c, pat(6));
    chk("R11 no stray write", 32'(wr_cnt - w0), 0);

    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    step(1'b0, 1'b1, o); step(1'b0, 1'b1, o);
    for (int i = 0; i < 5; i++) step(1'b1, 1'b1, o);
    step(1'b0, 1'b0, o);
    idle(1);
    dr_scan(32, 32'h0, c);
    chk("R1 tms reset from shift-dr", c, IDV);

    ir_scan(5'h1C, ic);
    step(1'b1, 1'b0, o); step(1'b0, 1'b0, o); step(1'b0, 1'b0, o);
    step(1'b0, 1'b1, o); step(1'b0, 1'b0, o);
    trst_n = 1'b0;
    #1 chk("R1 async trst clears tdo", 32'(tdo), 0);
    tms = 1'b1;
    idle(0);
    @(negedge tck); #1 trst_n = 1'b1; tms = 1'b0;
    idle(1);
    dr_scan(32, 32'h0, c);
    chk("R1 idcode after trst", c, IDV);
    chk("R5 pwr_ctrl cleared by trst", 32'(pwr_ctrl), 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule